// File: doc/BRIEF.md
# E1 Time Slot 0 Transmit Inserter

This block sits in the transmit path of an E1 framer that uses the two-frame (doubleframe) structure without CRC-4. It takes a byte-wide stream, one byte per time slot and 32 slots per frame. Each byte that carries the frame strobe is time slot 0. The block rewrites that byte and passes every other slot through unchanged. Outgoing frames alternate between alignment frames and non-alignment frames. For every field of time slot 0, configuration picks either a locally generated value or the bit already on the input byte. A single switch also passes the whole slot through untouched.

Byte numbering follows line order: bit 1 is sent first and sits at `data[7]`, and bit 8 sits at `data[0]`. Both stream sides use valid/ready. A byte moves when valid and ready are both high at a rising clock edge. The block holds one byte in an output register and accepts a new input byte whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output byte and its strobe stay frozen. The configuration inputs and `rx_lfa` are plain levels, sampled at the cycle the time slot 0 byte is accepted.

Top module: `e1_ts0_inserter`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and the first frame strobe accepted after reset starts an alignment frame.
- R2: With whole-slot transparency off, time slot 0 of an alignment frame is bit 1 followed by the fixed pattern 0011011, so `data[6:0]` = 7'b0011011. Bit 1 comes from `cfg_si_align`.
- R3: With whole-slot transparency off, time slot 0 of a non-alignment frame has the following layout. Bit 1 (`data[7]`) comes from `cfg_si_nonalign`. Bit 2 (`data[6]`) is 1. Bit 3 (`data[5]`) is the alarm bit, taken from `cfg_alarm`. Bits 4 to 8 (`data[4:0]`) come from `cfg_spare[4:0]`, where `cfg_spare[4]` is bit 4.
- R4: Each accepted frame strobe flips the frame type, so alignment and non-alignment frames strictly alternate.
- R5: When `cfg_whole_transp` is 1, time slot 0 leaves with all eight bits equal to the input byte, in both frame types.
- R6: `cfg_pass_si_align` and `cfg_pass_si_nonalign` each make bit 1 follow the input byte, the first in alignment frames and the second in non-alignment frames.
- R7: In non-alignment frames, `cfg_pass_alarm` makes bit 3 follow the input byte, and each bit of `cfg_pass_spare[4:0]` makes the matching bit of `data[4:0]` follow the input byte.
- R8: With `cfg_auto_alarm` set and the alarm bit not passed through, the alarm bit of non-alignment frames equals `rx_lfa` instead of `cfg_alarm`.
- R9: Slots other than time slot 0 leave unchanged, with the same one-register latency as time slot 0. The frame strobe travels with its byte on `out_sof`.
- R10: `in_ready` is high whenever `out_valid` is low. While `out_valid` is high and `out_ready` is low, `out_data` and `out_sof` hold their values. No byte is lost, duplicated or reordered.
- R11: The alarm and spare pass-through enables have no effect on alignment frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input slot byte, bit 1 at bit 7 |
| in_sof | input | 1 | Input byte is time slot 0 |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output slot byte with time slot 0 inserted |
| out_sof | output | 1 | Output byte is time slot 0 |
| cfg_whole_transp | input | 1 | Pass the whole of time slot 0 through |
| cfg_pass_si_align | input | 1 | Pass bit 1 through in alignment frames |
| cfg_pass_si_nonalign | input | 1 | Pass bit 1 through in non-alignment frames |
| cfg_pass_alarm | input | 1 | Pass the alarm bit through |
| cfg_pass_spare | input | 5 | Per-bit pass-through of spare bits 4 to 8 |
| cfg_si_align | input | 1 | Local bit 1 for alignment frames |
| cfg_si_nonalign | input | 1 | Local bit 1 for non-alignment frames |
| cfg_alarm | input | 1 | Local alarm bit |
| cfg_spare | input | 5 | Local spare bits 4 to 8 |
| cfg_auto_alarm | input | 1 | Drive the alarm bit from `rx_lfa` |
| rx_lfa | input | 1 | Receive side reports loss of frame alignment |

## Verification
The bench goes after five corner cases.

The frame type right after reset and at each later strobe: a design whose phase starts or toggles wrongly swaps the pattern and the service-word bits between frames. The per-field enables in the frame type where they must not act: a design that lets the alarm or spare masks touch alignment frames corrupts the 0011011 pattern. Automatic alarm against an explicit pass-through of the same bit: a wrong priority shows a reported loss of alignment where the input bit should appear. Whole-slot transparency combined with every mask set: a wrong priority puts local values into a slot that must pass through untouched.

Random back-pressure on the output checks that a stalled byte is held rather than overwritten. A design that gets this wrong drops or repeats slots, and the phase of every later frame shifts.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int SLOT_W = 8;
  localparam int SPARE_W = 5;
  localparam logic [SLOT_W-2:0] ALIGN_WORD = 7'b0011011;

  // one entry per locally generated field of time slot 0
  typedef struct packed {
    logic               si_align;
    logic               si_nonalign;
    logic               alarm;
    logic [SPARE_W-1:0] spare;
  } ts0_fields_t;
endpackage

// File: rtl/e1_frame_phase.sv
module e1_frame_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sof,
  output logic nonalign
);
  logic phase_q;

  // phase of the frame opened by the strobe currently offered
  assign nonalign = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else if (take && sof) phase_q <= ~phase_q;
  end
endmodule

// File: rtl/e1_ts0_build.sv
module e1_ts0_build
  import e1_ts0_pkg::*;
(
  input  logic              nonalign,
  input  logic              whole_transp,
  input  ts0_fields_t       pass,
  input  ts0_fields_t       local_val,
  input  logic              auto_alarm,
  input  logic              rx_lfa,
  input  logic [SLOT_W-1:0] din,
  output logic [SLOT_W-1:0] dout
);
  logic [SPARE_W-1:0] spare_bits;
  logic               alarm_src;
  logic               alarm_bit;
  logic               si_bit;
  logic [SLOT_W-1:0]  nonalign_word;
  logic [SLOT_W-1:0]  align_word;

  genvar gi;
  generate
    for (gi = 0; gi < SPARE_W; gi++) begin : g_spare
      assign spare_bits[gi] = pass.spare[gi] ? din[gi] : local_val.spare[gi];
    end
  endgenerate

  assign alarm_src = auto_alarm ? rx_lfa : local_val.alarm;
  assign alarm_bit = pass.alarm ? din[SLOT_W-3] : alarm_src;

  always_comb begin
    if (nonalign) si_bit = pass.si_nonalign ? din[SLOT_W-1] : local_val.si_nonalign;
    else          si_bit = pass.si_align    ? din[SLOT_W-1] : local_val.si_align;
  end

  assign align_word    = {si_bit, ALIGN_WORD};
  assign nonalign_word = {si_bit, 1'b1, alarm_bit, spare_bits};

  always_comb begin
    if (whole_transp)  dout = din;
    else if (nonalign) dout = nonalign_word;
    else               dout = align_word;
  end
endmodule

// File: rtl/e1_stream_reg.sv
module e1_stream_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign s_ready = !vld_q || m_ready;
  assign m_valid = vld_q;
  assign m_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (s_ready) begin
      vld_q <= s_valid;
      if (s_valid) dat_q <= s_data;
    end
  end
endmodule

// File: rtl/e1_ts0_inserter.sv
module e1_ts0_inserter
  import e1_ts0_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SLOT_W-1:0]  in_data,
  input  logic               in_sof,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SLOT_W-1:0]  out_data,
  output logic               out_sof,
  input  logic               cfg_whole_transp,
  input  logic               cfg_pass_si_align,
  input  logic               cfg_pass_si_nonalign,
  input  logic               cfg_pass_alarm,
  input  logic [SPARE_W-1:0] cfg_pass_spare,
  input  logic               cfg_si_align,
  input  logic               cfg_si_nonalign,
  input  logic               cfg_alarm,
  input  logic [SPARE_W-1:0] cfg_spare,
  input  logic               cfg_auto_alarm,
  input  logic               rx_lfa
);
  localparam int PIPE_W = SLOT_W + 1;

  ts0_fields_t       pass_mask;
  ts0_fields_t       local_val;
  logic              nonalign;
  logic              take;
  logic [SLOT_W-1:0] ts0_byte;
  logic [SLOT_W-1:0] slot_byte;
  logic [PIPE_W-1:0] pipe_out;

  assign pass_mask = '{si_align: cfg_pass_si_align, si_nonalign: cfg_pass_si_nonalign,
                       alarm: cfg_pass_alarm, spare: cfg_pass_spare};
  assign local_val = '{si_align: cfg_si_align, si_nonalign: cfg_si_nonalign,
                       alarm: cfg_alarm, spare: cfg_spare};

  assign take = in_valid && in_ready;

  e1_frame_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .sof      (in_sof),
    .nonalign (nonalign)
  );

  e1_ts0_build u_build (
    .nonalign     (nonalign),
    .whole_transp (cfg_whole_transp),
    .pass         (pass_mask),
    .local_val    (local_val),
    .auto_alarm   (cfg_auto_alarm),
    .rx_lfa       (rx_lfa),
    .din          (in_data),
    .dout         (ts0_byte)
  );

  assign slot_byte = in_sof ? ts0_byte : in_data;

  e1_stream_reg #(.W(PIPE_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  ({in_sof, slot_byte}),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pipe_out)
  );

  assign out_sof  = pipe_out[PIPE_W-1];
  assign out_data = pipe_out[SLOT_W-1:0];
endmodule

// File: rtl/e1_ts0_checker.sv
module e1_ts0_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       cfg_whole_transp,
  input logic       cfg_pass_alarm,
  input logic       cfg_auto_alarm,
  input logic       rx_lfa
);
  logic acc;
  logic odd_q;

  assign acc = in_valid && in_ready;

  // independent frame phase, advanced on accepted strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) odd_q <= 1'b0;
    else if (acc && in_sof) odd_q <= ~odd_q;
  end

  assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));

  assert_slot_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_sof) |=> (out_valid && !out_sof && out_data == $past(in_data)));

  assert_whole_transp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sof && cfg_whole_transp) |=> (out_sof && out_data == $past(in_data)));

  assert_align_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sof && !cfg_whole_transp && !odd_q) |=> (out_data[6:0] == 7'b0011011));

  assert_nonalign_bit2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sof && !cfg_whole_transp && odd_q) |=> out_data[6]);

  assert_auto_alarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sof && !cfg_whole_transp && odd_q && cfg_auto_alarm && !cfg_pass_alarm)
      |=> (out_data[5] == $past(rx_lfa)));
endmodule

bind e1_ts0_inserter e1_ts0_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .in_ready         (in_ready),
  .in_data          (in_data),
  .in_sof           (in_sof),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_data         (out_data),
  .out_sof          (out_sof),
  .cfg_whole_transp (cfg_whole_transp),
  .cfg_pass_alarm   (cfg_pass_alarm),
  .cfg_auto_alarm   (cfg_auto_alarm),
  .rx_lfa           (rx_lfa)
);

// File: tb/sim_e1_ts0_inserter.sv
module sim_e1_ts0_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sof = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sof;
  logic       whole = 1'b0, p_sia = 1'b0, p_sin = 1'b0, p_alm = 1'b0;
  logic [4:0] p_spare = '0;
  logic       si_a = 1'b0, si_n = 1'b0, alm = 1'b0, auto_alm = 1'b0, lfa = 1'b0;
  logic [4:0] spare = '0;

  int errors = 0;
  int checks = 0;
  bit frame_odd = 1'b0;
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  e1_ts0_inserter u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .cfg_whole_transp(whole), .cfg_pass_si_align(p_sia), .cfg_pass_si_nonalign(p_sin),
    .cfg_pass_alarm(p_alm), .cfg_pass_spare(p_spare), .cfg_si_align(si_a),
    .cfg_si_nonalign(si_n), .cfg_alarm(alm), .cfg_spare(spare),
    .cfg_auto_alarm(auto_alm), .rx_lfa(lfa)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected time slot 0, from the requirements
  function automatic logic [7:0] exp_ts0(input bit odd, input logic [7:0] d);
    logic [7:0] r;
    if (whole) return d;                                   // R5
    if (!odd) return {(p_sia ? d[7] : si_a), 7'b0011011};  // R2 R6 R11
    r[7] = p_sin ? d[7] : si_n;                            // R3 R6
    r[6] = 1'b1;
    r[5] = p_alm ? d[5] : (auto_alm ? lfa : alm);          // R7 R8
    for (int i = 0; i < 5; i++) r[i] = p_spare[i] ? d[i] : spare[i];
    return r;
  endfunction

  task automatic send_byte(input logic [7:0] d, input bit sof);
    bit acc;
    in_valid = 1'b1; in_data = d; in_sof = sof;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #2;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  // driver: pushes expected bytes, then offers them
  task automatic send_frame(input logic [7:0] ts0_in, input string tag);
    for (int s = 0; s < 32; s++) begin
      logic [7:0] d;
      d = (s == 0) ? ts0_in : 8'(s * 37 + ts0_in);
      if (s == 0) begin
        exp_q.push_back({1'b1, exp_ts0(frame_odd, d)});
        tag_q.push_back(tag);
      end else begin
        exp_q.push_back({1'b0, d});
        tag_q.push_back("R9");
      end
      send_byte(d, s == 0);
    end
    frame_odd = ~frame_odd;   // R4
  endtask

  // output ready pattern
  initial forever begin
    @(posedge clk); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_en ? lfsr[0] : 1'b1;
  end

  // monitor: pops and compares, plus stall hold check
  initial begin
    bit         was_stall = 1'b0;
    logic [8:0] held = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (was_stall) check("R10 hold", {out_valid, out_sof, out_data}, {1'b1, held});
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check("R10 extra byte", {out_sof, out_data}, 9'h1FF);
          else check(tag_q.pop_front(), {out_sof, out_data}, exp_q.pop_front());
        end
        was_stall = out_valid && !out_ready;
        held = {out_sof, out_data};
      end
    end
  end

  task automatic run_all();
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset out_valid", {8'h0, out_valid}, 9'h0);
    check("R1 reset in_ready", {8'h0, in_ready}, 9'h1);
    rst_n = 1'b1;
    @(posedge clk); #2;
    si_a = 1'b1; si_n = 1'b0; alm = 1'b1; spare = 5'b10110;
    send_frame(8'h00, "R1 R2 first frame aligned");
    send_frame(8'hFF, "R3 nonalign");
    send_frame(8'h55, "R4 alternation");
    send_frame(8'hAA, "R4 alternation");
    whole = 1'b1; p_sia = 1'b1; p_alm = 1'b1; p_spare = 5'b11111;
    send_frame(8'h3C, "R5 whole align");
    send_frame(8'hC3, "R5 whole nonalign");
    whole = 1'b0; p_alm = 1'b0; p_spare = '0;
    si_a = 1'b0; si_n = 1'b0; p_sin = 1'b1;
    send_frame(8'h80, "R6 si align passed");
    send_frame(8'h80, "R6 si nonalign passed");
    p_sia = 1'b0; p_sin = 1'b0;
    p_alm = 1'b1; p_spare = 5'b01011; alm = 1'b0; spare = 5'b10100;
    send_frame(8'h3F, "R11 masks ignored in align");
    send_frame(8'h2B, "R7 field pass nonalign");
    p_spare = 5'b10100;
    send_frame(8'h00, "R11 masks ignored in align");
    send_frame(8'h0B, "R7 field pass nonalign");
    p_alm = 1'b0; p_spare = '0; auto_alm = 1'b1; alm = 1'b0; lfa = 1'b1;
    send_frame(8'h00, "R2 align with auto");
    send_frame(8'h00, "R8 auto lfa high");
    alm = 1'b1; lfa = 1'b0;
    send_frame(8'h00, "R2 align with auto");
    send_frame(8'hFF, "R8 auto lfa low");
    p_alm = 1'b1; lfa = 1'b1;
    send_frame(8'h00, "R2 align");
    send_frame(8'h00, "R7 pass beats auto");
    p_alm = 1'b0; auto_alm = 1'b0; stall_en = 1'b1;
    for (int f = 0; f < 6; f++) send_frame(8'(f * 29 + 7), "R10 stalled frame");
    stall_en = 1'b0;
    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(posedge clk);
    #2;
    check("R10 queue drained", {1'b0, 8'(exp_q.size())}, 9'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule